// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Match Interrupt

This block keeps wall time as a single 32-bit unsigned count of seconds. A prescaler divides the block clock by a parameter `DIV` to make a one-second update strobe. The count advances on that strobe only when counting is switched on. Software never writes the count directly. It writes a staging register, and the staged value replaces the count at the next update strobe. A compare register lets software request an interrupt for a chosen second. Interrupt delivery is gated by two control bits, an enable and a mask.

Software reaches the block over a plain 32-bit register bus: a byte address, a write strobe with data, and a read strobe with combinational read data. The pending interrupt is acknowledged by reading a dedicated acknowledge location. Any typical use follows the same pattern. Software stages a start time, turns on counting, programs a compare second and enables the interrupt. It then reads the acknowledge location in its handler.

Top module: `sec_rtc`

## Requirements
- R1: After reset every location reads 0 except the identity word at 0x1C, which reads the `VERSION_ID` parameter, and `irq` is 0.
- R2: The locations are: 0x00 live count, 0x04 compare second, 0x08 staged load value, 0x0C control, 0x10 gated status, 0x14 sticky status, 0x18 acknowledge, 0x1C identity. The compare and staging registers read back what was last written. Control reads back bits 3:0 of the write: bit 0 interrupt enable, bit 1 interrupt mask, bit 2 run, bit 3 rollover enable. Its upper bits read 0. The status words report in bit 0 only. `bus_rdata` is 0 whenever `bus_rd` is low.
- R3: Writes to 0x00, 0x10, 0x14, 0x18 and 0x1C change nothing.
- R4: While run is 1, the update strobe occurs once every `DIV` clock cycles. The first strobe comes `DIV` edges after the edge that set run. Each strobe without a staged value adds one to the count.
- R5: While run is 0, the prescaler and the count hold their values, and a staged value waits.
- R6: A write to 0x08 leaves the count unchanged until the next update strobe. At that strobe the count takes the staged value in place of an increment.
- R7: A strobe at count 0xFFFFFFFF gives 0 when rollover enable is 1. It keeps 0xFFFFFFFF when rollover enable is 0.
- R8: When the value a strobe writes into the count equals the compare second, the sticky status bit sets. This applies to a load, an increment or a hold. The bit stays set while the count moves on.
- R9: The gated status bit and `irq` both equal sticky status AND enable AND NOT mask.
- R10: A read of 0x18 returns 0 and clears sticky status at the end of that cycle. A compare hit in the same cycle wins, and the bit stays set.
- R11: A staging write in the same cycle as a strobe does not affect that strobe. The previously staged value, if any, is applied. The new value stays staged for the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the prescaler reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | DATA_W | Combinational read data, 0 when idle |
| irq | output | 1 | Level interrupt request |

## Verification
Two situations are the hardest to reach from the ports. The first is a staging write landing on the very cycle of an update strobe. The second is an acknowledge read landing on the cycle of a compare hit. A single scripted access hits either cycle only by luck. The stimulus therefore holds the write strobe high on consecutive cycles for several whole update periods. It then holds the acknowledge read high across a window that contains a compare hit, so every phase of the prescaler is covered. A behavioural model in the bench tracks the prescaler phase, the staged value and sticky status on each clock. It compares the read data and `irq` at every cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  // word index of each location (byte address >> 2)
  localparam int IDX_COUNT = 0;
  localparam int IDX_MATCH = 1;
  localparam int IDX_LOAD  = 2;
  localparam int IDX_CTRL  = 3;
  localparam int IDX_MSTAT = 4;
  localparam int IDX_RSTAT = 5;
  localparam int IDX_ACK   = 6;
  localparam int IDX_IDENT = 7;

  localparam int CTRL_BITS = 4;

  // packed so that ie lands in bit 0 and wrap in bit 3
  typedef struct packed {
    logic wrap;
    logic run;
    logic mask;
    logic ie;
  } ctrl_t;

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q, pre_d;

  assign tick = run && (pre_q == LAST);

  always_comb begin
    pre_d = pre_q;
    if (run) begin
      if (pre_q == LAST) pre_d = '0;
      else               pre_d = pre_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else if (run) pre_q <= pre_d;
  end

endmodule

// File: rtl/rtc_sec_core.sv
module rtc_sec_core #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wrap_en,
  input  logic         load_wr,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] match_val,
  output logic [W-1:0] cnt,
  output logic         pend,
  output logic         hit
);

  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q, cnt_d, upd_val;
  logic         pend_q, pend_d;

  // value the next strobe writes into the count
  always_comb begin
    if (pend_q)             upd_val = load_val;
    else if (cnt_q == TOP)  upd_val = wrap_en ? '0 : TOP;
    else                    upd_val = cnt_q + W'(1);
  end

  always_comb begin
    cnt_d  = tick ? upd_val : cnt_q;
    pend_d = pend_q;
    if (tick)    pend_d = 1'b0;
    if (load_wr) pend_d = 1'b1;
  end

  assign hit  = tick && (upd_val == match_val);
  assign cnt  = cnt_q;
  assign pend = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (tick) cnt_q <= cnt_d;
      if (tick || load_wr) pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  parameter logic [DATA_W-1:0] VERSION_ID = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] cnt,
  input  logic              hit,
  output ctrl_t             ctrl,
  output logic              load_wr,
  output logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] match_val,
  output logic              raw,
  output logic              irq
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic              aligned;
  logic              we_match, we_load, we_ctrl, ack_rd;
  logic [DATA_W-1:0] match_q, load_q;
  ctrl_t             ctrl_q, ctrl_d;
  logic              raw_q, raw_d;
  logic              gated;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  assign we_match = bus_wr && aligned && (idx == IDX_W'(IDX_MATCH));
  assign we_load  = bus_wr && aligned && (idx == IDX_W'(IDX_LOAD));
  assign we_ctrl  = bus_wr && aligned && (idx == IDX_W'(IDX_CTRL));
  assign ack_rd   = bus_rd && aligned && (idx == IDX_W'(IDX_ACK));

  assign ctrl_d = ctrl_t'(bus_wdata[CTRL_BITS-1:0]);

  always_comb begin
    raw_d = raw_q;
    if (ack_rd) raw_d = 1'b0;
    if (hit)    raw_d = 1'b1;
  end

  assign gated = raw_q && ctrl_q.ie && !ctrl_q.mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      load_q  <= '0;
      ctrl_q  <= '0;
      raw_q   <= 1'b0;
    end else begin
      if (we_match) match_q <= bus_wdata;
      if (we_load)  load_q  <= bus_wdata;
      if (we_ctrl)  ctrl_q  <= ctrl_d;
      if (hit || ack_rd) raw_q <= raw_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && aligned) begin
      case (idx)
        IDX_W'(IDX_COUNT): bus_rdata = cnt;
        IDX_W'(IDX_MATCH): bus_rdata = match_q;
        IDX_W'(IDX_LOAD):  bus_rdata = load_q;
        IDX_W'(IDX_CTRL):  bus_rdata = DATA_W'(ctrl_q);
        IDX_W'(IDX_MSTAT): bus_rdata = DATA_W'(gated);
        IDX_W'(IDX_RSTAT): bus_rdata = DATA_W'(raw_q);
        IDX_W'(IDX_IDENT): bus_rdata = VERSION_ID;
        default:           bus_rdata = '0;
      endcase
    end
  end

  assign ctrl      = ctrl_q;
  assign load_wr   = we_load;
  assign load_val  = load_q;
  assign match_val = match_q;
  assign raw       = raw_q;
  assign irq       = gated;

endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
  import rtc_pkg::*;
#(
  parameter int unsigned DIV    = 32768,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  parameter logic [DATA_W-1:0] VERSION_ID = DATA_W'(32'h0002_0107)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  ctrl_t             ctrl;
  logic              tick;
  logic              load_wr;
  logic [DATA_W-1:0] load_val, match_val, cnt;
  logic              pend, hit, raw;

  rtc_prescaler #(.DIV(DIV)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (ctrl.run),
    .tick (tick)
  );

  rtc_sec_core #(.W(DATA_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .wrap_en  (ctrl.wrap),
    .load_wr  (load_wr),
    .load_val (load_val),
    .match_val(match_val),
    .cnt      (cnt),
    .pend     (pend),
    .hit      (hit)
  );

  rtc_regs #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .VERSION_ID(VERSION_ID)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rd   (bus_rd),
    .bus_rdata(bus_rdata),
    .cnt      (cnt),
    .hit      (hit),
    .ctrl     (ctrl),
    .load_wr  (load_wr),
    .load_val (load_val),
    .match_val(match_val),
    .raw      (raw),
    .irq      (irq)
  );

endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk #(
  parameter int unsigned DIV    = 32768,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              run,
  input logic              wrap,
  input logic              pend,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] load_val,
  input logic              hit,
  input logic              raw,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr
);

  localparam logic [DATA_W-1:0] TOP = '1;

  logic ack;
  assign ack = bus_rd && (bus_addr == ADDR_W'(24));

  // run cycles seen since the last strobe
  logic [31:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    gap_q <= '0;
    else if (tick) gap_q <= '0;
    else if (run)  gap_q <= gap_q + 32'd1;
  end

  a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (gap_q == 32'(DIV - 1)));

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pend && cnt != TOP) |=> (cnt == $past(cnt) + DATA_W'(1)));

  a_r5_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt));

  a_r6_no_early_change: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  a_r6_load_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pend) |=> (cnt == $past(load_val)));

  a_r7_hold_top: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pend && cnt == TOP && !wrap) |=> (cnt == TOP));

  a_r7_roll: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pend && cnt == TOP && wrap) |=> (cnt == '0));

  a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> raw);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (raw && !ack) |=> raw);

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !hit) |=> !raw);

endmodule

bind sec_rtc sec_rtc_chk #(
  .DIV   (DIV),
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick),
  .run     (ctrl.run),
  .wrap    (ctrl.wrap),
  .pend    (pend),
  .cnt     (cnt),
  .load_val(load_val),
  .hit     (hit),
  .raw     (raw),
  .bus_rd  (bus_rd),
  .bus_addr(bus_addr)
);

// File: tb/sec_rtc_bench.sv
`timescale 1ns/1ps
module sec_rtc_bench;

  localparam int DIV = 6;
  localparam logic [31:0] VER = 32'h0002_0107;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  addr;
  logic        wr, rd;
  logic [31:0] wdata, rdata;
  logic        irq;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;
  bit done = 0;
  string phase_req = "R2";

  always #4 clk = ~clk;

  sec_rtc #(.DIV(DIV), .VERSION_ID(VER)) u_sec_rtc (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rd(rd), .bus_rdata(rdata), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_cnt, m_match, m_load;
  logic [3:0]  m_ctrl;
  logic        m_pend, m_raw;
  int          m_pre;

  always @(posedge clk or negedge rst_n) begin : model
    logic        tk, hitm, ackm;
    logic [31:0] nv;
    if (!rst_n) begin
      m_cnt = 0; m_match = 0; m_load = 0; m_ctrl = 0;
      m_pend = 0; m_raw = 0; m_pre = 0;
    end else begin
      tk = m_ctrl[2] && (m_pre == DIV - 1);
      if (m_pend)                    nv = m_load;
      else if (m_cnt == 32'hFFFFFFFF) nv = m_ctrl[3] ? 32'h0 : m_cnt;
      else                           nv = m_cnt + 1;
      hitm = tk && (nv == m_match);
      ackm = rd && (addr == 5'h18);
      if (m_ctrl[2]) m_pre = (m_pre == DIV - 1) ? 0 : m_pre + 1;
      if (tk) m_cnt = nv;
      if (tk) m_pend = 0;
      if (hitm) m_raw = 1; else if (ackm) m_raw = 0;
      if (wr && addr == 5'h08) begin m_load = wdata; m_pend = 1; end
      if (wr && addr == 5'h04) m_match = wdata;
      if (wr && addr == 5'h0C) m_ctrl = wdata[3:0];
    end
  end

  function automatic logic [31:0] m_rdata(logic [4:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    case (a[4:2])
      3'd0: return m_cnt;
      3'd1: return m_match;
      3'd2: return m_load;
      3'd3: return {28'h0, m_ctrl};
      3'd4: return {31'h0, m_raw & m_ctrl[0] & ~m_ctrl[1]};
      3'd5: return {31'h0, m_raw};
      3'd6: return 32'h0;
      default: return VER;
    endcase
  endfunction

  // every-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      check("R9 irq", {31'h0, irq}, {31'h0, m_raw & m_ctrl[0] & ~m_ctrl[1]});
      if (rd) check(phase_req, rdata, m_rdata(addr));
      else    check("R2 idle", rdata, 32'h0);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      nerr++; nchk++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  // ---------------- bus tasks (start and end at a negedge) ----------------
  task automatic wr_reg(logic [4:0] a, logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(logic [4:0] a, output logic [31:0] v);
    addr = a; rd = 1'b1;
    #3 v = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic poll(logic [4:0] a, logic [31:0] want, int maxn, output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int k = 0; k < maxn && !ok; k++) begin
      rd_reg(a, v);
      if (v == want) ok = 1;
    end
  endtask

  initial begin
    logic [31:0] v;
    bit ok;
    rst_n = 0; wr = 0; rd = 0; addr = 0; wdata = 0;
    idle(4);
    rst_n = 1;
    idle(1);

    // R1 reset values
    check("R1 irq", {31'h0, irq}, 32'h0);
    for (int i = 0; i < 8; i++) begin
      rd_reg(5'(i * 4), v);
      check("R1", v, (i == 7) ? VER : 32'h0);
    end

    // R2 read back
    wr_reg(5'h04, 32'h0000_0013);
    rd_reg(5'h04, v); check("R2 match", v, 32'h13);
    wr_reg(5'h0C, 32'hFFFF_FFFA);
    rd_reg(5'h0C, v); check("R2 ctrl", v, 32'hA);
    wr_reg(5'h0C, 32'h0);

    // R3 read-only locations
    wr_reg(5'h00, 32'hDEAD_BEEF);
    wr_reg(5'h14, 32'h1);
    wr_reg(5'h10, 32'h1);
    wr_reg(5'h1C, 32'h0);
    rd_reg(5'h00, v); check("R3 count", v, 32'h0);
    rd_reg(5'h14, v); check("R3 raw", v, 32'h0);
    rd_reg(5'h1C, v); check("R3 ident", v, VER);

    // R5 staged load waits while stopped
    wr_reg(5'h08, 32'h10);
    idle(20);
    rd_reg(5'h00, v); check("R5 held", v, 32'h0);
    rd_reg(5'h08, v); check("R6 staged", v, 32'h10);

    // R4/R6 latency: strobe DIV edges after the enabling edge
    wr_reg(5'h0C, 32'h5);
    idle(5);
    rd_reg(5'h00, v); check("R6 not yet", v, 32'h0);
    idle(1);
    rd_reg(5'h00, v); check("R6 loaded", v, 32'h10);
    idle(5);
    rd_reg(5'h00, v); check("R4 step", v, 32'h11);

    // R8 match sets sticky status, R9 gating
    poll(5'h00, 32'h13, 40, ok); check("R8 reach", {31'h0, ok}, 32'h1);
    rd_reg(5'h14, v); check("R8 raw", v, 32'h1);
    rd_reg(5'h10, v); check("R9 gated", v, 32'h1);
    check("R9 irq on", {31'h0, irq}, 32'h1);
    poll(5'h00, 32'h14, 40, ok);
    rd_reg(5'h14, v); check("R8 sticky", v, 32'h1);
    wr_reg(5'h0C, 32'h7);
    rd_reg(5'h10, v); check("R9 masked", v, 32'h0);
    check("R9 irq masked", {31'h0, irq}, 32'h0);
    rd_reg(5'h14, v); check("R9 raw kept", v, 32'h1);
    wr_reg(5'h0C, 32'h4);
    check("R9 irq disabled", {31'h0, irq}, 32'h0);
    wr_reg(5'h0C, 32'h5);
    check("R9 irq again", {31'h0, irq}, 32'h1);

    // R10 acknowledge read
    rd_reg(5'h18, v); check("R10 data", v, 32'h0);
    rd_reg(5'h14, v); check("R10 cleared", v, 32'h0);
    check("R10 irq", {31'h0, irq}, 32'h0);

    // R7 top of range
    wr_reg(5'h0C, 32'h4);
    wr_reg(5'h04, 32'hFFFF_FFFF);
    wr_reg(5'h08, 32'hFFFF_FFFE);
    poll(5'h00, 32'hFFFF_FFFF, 40, ok); check("R7 reach top", {31'h0, ok}, 32'h1);
    rd_reg(5'h14, v); check("R8 top hit", v, 32'h1);
    idle(3 * DIV);
    rd_reg(5'h00, v); check("R7 hold", v, 32'hFFFF_FFFF);
    wr_reg(5'h0C, 32'hC);
    poll(5'h00, 32'h0, 40, ok); check("R7 roll", {31'h0, ok}, 32'h1);
    rd_reg(5'h18, v);

    // R11 staging writes on every cycle, covering every prescaler phase
    phase_req = "R11";
    wr_reg(5'h0C, 32'h5);
    for (int i = 0; i < 4 * DIV; i++) begin
      addr = 5'h08; wdata = 32'h100 + 32'(i); wr = 1'b1;
      @(negedge clk);
    end
    wr = 1'b0;
    idle(2 * DIV);
    rd_reg(5'h00, v);
    rd_reg(5'h08, v); check("R11 last staged", v, 32'h100 + 32'(4 * DIV - 1));

    // R10 acknowledge held across a compare hit: hit wins in that cycle
    phase_req = "R10";
    wr_reg(5'h04, 32'h200);
    wr_reg(5'h08, 32'h1FE);
    addr = 5'h18; rd = 1'b1;
    repeat (4 * DIV) @(negedge clk);
    rd = 1'b0;
    rd_reg(5'h14, v); check("R10 after window", v, 32'h0);
    rd_reg(5'h00, v); check("R10 count past", {31'h0, (v >= 32'h200)}, 32'h1);

    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule